// File: doc/BRIEF.md
# Burst Address Sequencer

This block is the address and control front end of a synchronous pipelined burst memory. On every rising clock edge it looks at two active-low start strobes, an active-low advance input, three chip selects, a burst-order select and a write request. From these it registers the address to present to the memory array, a cycle kind and a read/write flag. The memory array, data path and output drivers sit outside it.

A burst starts from either strobe. The processor-side strobe starts the cycle. The controller-side strobe starts it only when the processor-side strobe is inactive or blocked. On a start, the external address is captured. Its two lowest bits become the burst start value, and the following beats step those bits through four positions. The order-select input picks the stepping rule. When it is low, the beat number is added to the start value, modulo 4. When it is high, the beat number is XORed into the start value. Holding the advance input high pauses the burst on the current address.

The outputs are registered. Inputs sampled on one edge appear on the outputs after that same edge.

Top module: `burst_addr_seq`

## Requirements
- R1: When `pstrb_n` is low and `sel1_n` is low, the edge starts a read. `cyc_kind` becomes 01 (begin), `cyc_wr` becomes 0 and `mem_addr` takes `ext_addr`. This holds whatever `wr_req` and `cstrb_n` are.
- R2: When `cstrb_n` is low and the processor strobe is not starting a cycle, the edge starts a cycle with `cyc_kind` 01. `mem_addr` takes `ext_addr`, and `cyc_wr` takes `wr_req` sampled on that same edge.
- R3: On an edge that starts a cycle, `adv_n` has no effect. On the edges that follow, `adv_n` chooses between continue and suspend.
- R4: While `sel1_n` is high, a low `pstrb_n` has no effect. With `cstrb_n` high, such an edge behaves as an edge with no strobe.
- R5: A strobe that starts a cycle while the selects are not all active gives `cyc_kind` 00 (deselect) and `cyc_wr` 0. The active state is `sel1_n` low, `sel2` high and `sel3_n` low. An edge with no strobe while deselected stays deselected, and `mem_addr` holds its value.
- R6: With no strobe, `adv_n` low and a burst active, `cyc_kind` becomes 10 (continue). `mem_addr[1:0]` moves to the next burst position, the upper address bits hold, and `cyc_wr` takes `wr_req`.
- R7: With no strobe, `adv_n` high and a burst active, `cyc_kind` becomes 11 (suspend). `mem_addr` holds its value and `cyc_wr` takes `wr_req`.
- R8: While `order_xor` is 0, beat k of a burst has low address bits equal to (start + k) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R9: While `order_xor` is 1, beat k has low address bits equal to start XOR k. For example, start 10 gives 10, 11, 00, 01.
- R10: After the fourth beat, a further advance returns the low bits to the start value.
- R11: While `rst` is high on an edge, the outputs become `mem_addr` 0, `cyc_kind` 00 and `cyc_wr` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pstrb_n | input | 1 | Processor-side start strobe, active low |
| cstrb_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | Chip select, active low; also gates `pstrb_n` |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| order_xor | input | 1 | Burst order: 0 additive, 1 XOR |
| wr_req | input | 1 | Write request, active high |
| ext_addr | input | ADDR_W | External start address |
| mem_addr | output | ADDR_W | Registered array address |
| cyc_kind | output | 2 | Cycle kind: 00 deselect, 01 begin, 10 continue, 11 suspend |
| cyc_wr | output | 1 | Cycle is a write |

## Verification
The hardest case to reach is a full wrap under each order for every start value. Each of the eight combinations needs a fresh start followed by four uninterrupted advances, with the selects held active throughout. The stimulus loops over both orders and all four start values and issues a start and then four advances each time. The scoreboard model predicts every beat. The strobe-priority corners are reached by driving both strobes low on one edge, and by driving the processor strobe low while `sel1_n` is high, in the middle of an active burst.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    CYC_DESEL = 2'b00,
    CYC_BEGIN = 2'b01,
    CYC_CONT  = 2'b10,
    CYC_SUSP  = 2'b11
  } cyc_kind_t;

  // Low address bits of a given beat: additive or XOR order.
  function automatic logic [BEAT_W-1:0] beat_lsb(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input logic              xor_mode
  );
    logic [BEAT_W-1:0] sum;
    sum = start + beat;
    beat_lsb = xor_mode ? (start ^ beat) : sum;
  endfunction

  // Beat index after one advance; wraps naturally at four.
  function automatic logic [BEAT_W-1:0] beat_next(input logic [BEAT_W-1:0] beat);
    logic [BEAT_W-1:0] one;
    one = 1;
    beat_next = beat + one;
  endfunction

endpackage

// File: rtl/bsq_strobe_decode.sv
module bsq_strobe_decode (
  input  logic pstrb_n,
  input  logic cstrb_n,
  input  logic adv_n,
  input  logic sel1_n,
  input  logic sel2,
  input  logic sel3_n,
  input  logic active,
  output logic p_start,
  output logic c_start,
  output logic sel_ok,
  output logic do_load,
  output logic do_step,
  output logic do_hold,
  output logic do_desel
);

  logic strobe;

  // sel1_n high masks the processor strobe entirely.
  assign p_start = ~pstrb_n & ~sel1_n;
  // Controller strobe counts only when the processor strobe does not.
  assign c_start = ~cstrb_n & ~p_start;
  assign strobe  = p_start | c_start;
  assign sel_ok  = ~sel1_n & sel2 & ~sel3_n;

  always_comb begin
    do_load  = 1'b0;
    do_step  = 1'b0;
    do_hold  = 1'b0;
    do_desel = 1'b0;
    if (strobe) begin
      do_load  = sel_ok;
      do_desel = ~sel_ok;
    end else if (!active) begin
      do_desel = 1'b1;
    end else if (!adv_n) begin
      do_step = 1'b1;
    end else begin
      do_hold = 1'b1;
    end
  end

endmodule

// File: rtl/bsq_burst_counter.sv
module bsq_burst_counter
  import bsq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BEAT_W-1:0] beat_idx
);

  localparam int HI_W = ADDR_W - BEAT_W;

  logic [BEAT_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] lsb_q;
  logic [BEAT_W-1:0] beat_d;

  assign beat_d = beat_next(beat_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
      lsb_q  <= '0;
    end else if (load) begin
      base_q <= ext_addr[BEAT_W-1:0];
      beat_q <= '0;
      lsb_q  <= ext_addr[BEAT_W-1:0];
    end else if (step) begin
      beat_q <= beat_d;
      lsb_q  <= beat_lsb(base_q, beat_d, order_xor);
    end
  end

  generate
    if (HI_W > 0) begin : g_hi
      logic [HI_W-1:0] hi_q;
      always_ff @(posedge clk) begin
        if (rst)       hi_q <= '0;
        else if (load) hi_q <= ext_addr[ADDR_W-1:BEAT_W];
      end
      assign mem_addr = {hi_q, lsb_q};
    end else begin : g_lo_only
      assign mem_addr = lsb_q;
    end
  endgenerate

  assign beat_idx = beat_q;

endmodule

// File: rtl/bsq_cycle_reg.sv
module bsq_cycle_reg
  import bsq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  logic      p_start,
  input  logic      step,
  input  logic      hold,
  input  logic      desel,
  input  logic      wr_req,
  output cyc_kind_t kind,
  output logic      wr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind <= CYC_DESEL;
      wr   <= 1'b0;
    end else if (load) begin
      kind <= CYC_BEGIN;
      wr   <= p_start ? 1'b0 : wr_req;
    end else if (step) begin
      kind <= CYC_CONT;
      wr   <= wr_req;
    end else if (hold) begin
      kind <= CYC_SUSP;
      wr   <= wr_req;
    end else if (desel) begin
      kind <= CYC_DESEL;
      wr   <= 1'b0;
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pstrb_n,
  input  logic              cstrb_n,
  input  logic              adv_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              order_xor,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        cyc_kind,
  output logic              cyc_wr
);

  // Named internal events, visible to the bound checker.
  logic              ev_p_start;
  logic              ev_c_start;
  logic              ev_sel_ok;
  logic              ev_load;
  logic              ev_step;
  logic              ev_hold;
  logic              ev_desel;
  logic              burst_active;
  logic [BEAT_W-1:0] beat_idx;
  cyc_kind_t         kind_q;

  assign burst_active = (kind_q != CYC_DESEL);

  bsq_strobe_decode u_dec (
    .pstrb_n  (pstrb_n),
    .cstrb_n  (cstrb_n),
    .adv_n    (adv_n),
    .sel1_n   (sel1_n),
    .sel2     (sel2),
    .sel3_n   (sel3_n),
    .active   (burst_active),
    .p_start  (ev_p_start),
    .c_start  (ev_c_start),
    .sel_ok   (ev_sel_ok),
    .do_load  (ev_load),
    .do_step  (ev_step),
    .do_hold  (ev_hold),
    .do_desel (ev_desel)
  );

  bsq_burst_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load      (ev_load),
    .step      (ev_step),
    .order_xor (order_xor),
    .ext_addr  (ext_addr),
    .mem_addr  (mem_addr),
    .beat_idx  (beat_idx)
  );

  bsq_cycle_reg u_cyc (
    .clk     (clk),
    .rst     (rst),
    .load    (ev_load),
    .p_start (ev_p_start),
    .step    (ev_step),
    .hold    (ev_hold),
    .desel   (ev_desel),
    .wr_req  (wr_req),
    .kind    (kind_q),
    .wr      (cyc_wr)
  );

  assign cyc_kind = kind_q;

endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              pstrb_n,
  input logic              cstrb_n,
  input logic              adv_n,
  input logic              sel1_n,
  input logic              sel2,
  input logic              sel3_n,
  input logic              wr_req,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        cyc_kind,
  input logic              cyc_wr,
  input logic              ev_load,
  input logic              ev_step,
  input logic              ev_hold,
  input logic              ev_desel,
  input logic [1:0]        beat_idx
);

  logic all_sel;
  logic no_strobe;
  assign all_sel   = ~sel1_n & sel2 & ~sel3_n;
  assign no_strobe = cstrb_n & (pstrb_n | sel1_n);

  // R11: reset clears the outputs.
  a_r11_reset: assert property (@(posedge clk)
    rst |=> (cyc_kind == 2'b00 && !cyc_wr && mem_addr == '0));

  // R1, R3: processor strobe begins a read at the external address.
  a_r1_pstrb_read: assert property (@(posedge clk) disable iff (rst)
    (!pstrb_n && all_sel) |=> (cyc_kind == 2'b01 && !cyc_wr && mem_addr == $past(ext_addr)));

  // R2: controller strobe begins a cycle carrying the sampled write request.
  a_r2_cstrb_begin: assert property (@(posedge clk) disable iff (rst)
    (pstrb_n && !cstrb_n && all_sel) |=> (cyc_kind == 2'b01 && cyc_wr == $past(wr_req)));

  // R5: a strobe with a select inactive deselects.
  a_r5_deselect: assert property (@(posedge clk) disable iff (rst)
    (((!pstrb_n && !sel1_n) || !cstrb_n) && !all_sel) |=> (cyc_kind == 2'b00 && !cyc_wr));

  // R5: idle while deselected keeps the address.
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (no_strobe && cyc_kind == 2'b00) |=> (cyc_kind == 2'b00 && $stable(mem_addr)));

  // R6: an advance moves the low address bits.
  a_r6_step_moves: assert property (@(posedge clk) disable iff (rst)
    (no_strobe && !adv_n && cyc_kind != 2'b00) |=> (cyc_kind == 2'b10 && mem_addr[1:0] != $past(mem_addr[1:0])));

  // R7: suspend holds the address.
  a_r7_suspend_hold: assert property (@(posedge clk) disable iff (rst)
    (no_strobe && adv_n && cyc_kind != 2'b00) |=> (cyc_kind == 2'b11 && $stable(mem_addr) && cyc_wr == $past(wr_req)));

  // R10: the beat index returns to zero after four advances.
  a_r10_beat_wrap: assert property (@(posedge clk) disable iff (rst)
    (ev_step && beat_idx == 2'd3) |=> (beat_idx == 2'd0));

  // R6, R7: at most one action per edge.
  a_r6_one_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_load, ev_step, ev_hold, ev_desel}));

endmodule

bind burst_addr_seq bsq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pstrb_n  (pstrb_n),
  .cstrb_n  (cstrb_n),
  .adv_n    (adv_n),
  .sel1_n   (sel1_n),
  .sel2     (sel2),
  .sel3_n   (sel3_n),
  .wr_req   (wr_req),
  .ext_addr (ext_addr),
  .mem_addr (mem_addr),
  .cyc_kind (cyc_kind),
  .cyc_wr   (cyc_wr),
  .ev_load  (ev_load),
  .ev_step  (ev_step),
  .ev_hold  (ev_hold),
  .ev_desel (ev_desel),
  .beat_idx (beat_idx)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pstrb_n = 1'b1, cstrb_n = 1'b1, adv_n = 1'b1;
  logic          sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
  logic          order_xor = 1'b0, wr_req = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] mem_addr;
  logic [1:0]    cyc_kind;
  logic          cyc_wr;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .order_xor(order_xor),
    .wr_req(wr_req), .ext_addr(ext_addr), .mem_addr(mem_addr),
    .cyc_kind(cyc_kind), .cyc_wr(cyc_wr)
  );

  typedef struct packed {
    logic [1:0]    k;
    logic          w;
    logic [AW-1:0] a;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 0;

  // Reference model state
  logic [1:0]    m_kind = 2'b00;
  logic          m_wr = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [1:0]    m_start = 2'b00;
  int            m_beat = 0;

  task automatic apply(input logic r, input logic ps, input logic cs, input logic av,
                       input logic s1, input logic s2, input logic s3, input logic ox,
                       input logic w, input logic [AW-1:0] ea, input string tag);
    bit go_p, go_c, ok;
    int lo;
    @(negedge clk);
    rst = r; pstrb_n = ps; cstrb_n = cs; adv_n = av;
    sel1_n = s1; sel2 = s2; sel3_n = s3; order_xor = ox; wr_req = w; ext_addr = ea;
    go_p = (ps == 1'b0) && (s1 == 1'b0);
    go_c = !go_p && (cs == 1'b0);
    ok   = (s1 == 1'b0) && (s2 == 1'b1) && (s3 == 1'b0);
    if (r) begin
      m_kind = 2'b00; m_wr = 1'b0; m_addr = '0; m_start = 2'b00; m_beat = 0;
    end else if (go_p || go_c) begin
      if (ok) begin
        m_kind = 2'b01; m_wr = go_p ? 1'b0 : w; m_addr = ea;
        m_start = ea[1:0]; m_beat = 0;
      end else begin
        m_kind = 2'b00; m_wr = 1'b0;
      end
    end else if (m_kind == 2'b00) begin
      m_wr = 1'b0;
    end else if (av == 1'b0) begin
      m_beat = (m_beat + 1) % 4;
      if (ox) lo = int'(m_start) ^ m_beat;
      else    lo = (int'(m_start) + m_beat) % 4;
      m_addr[1:0] = lo[1:0];
      m_kind = 2'b10; m_wr = w;
    end else begin
      m_kind = 2'b11; m_wr = w;
    end
    exp_q.push_back('{k: m_kind, w: m_wr, a: m_addr});
    tag_q.push_back(tag);
  endtask

  // Shorthands with selects active.
  task automatic p_go(input logic [AW-1:0] ea, input logic ox, input logic w, input logic av, input string tag);
    apply(1'b0, 1'b0, 1'b1, av, 1'b0, 1'b1, 1'b0, ox, w, ea, tag);
  endtask
  task automatic c_go(input logic [AW-1:0] ea, input logic w, input string tag);
    apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, w, ea, tag);
  endtask
  task automatic idle(input logic av, input logic ox, input logic w, input string tag);
    apply(1'b0, 1'b1, 1'b1, av, 1'b0, 1'b1, 1'b0, ox, w, 20'h0BEEF, tag);
  endtask

  // Monitor: compares one item per clock, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if (cyc_kind !== e.k || cyc_wr !== e.w || mem_addr !== e.a) begin
          miscompares++;
          $display("FAIL %s: got kind=%b wr=%b addr=%h, expected kind=%b wr=%b addr=%h",
                   t, cyc_kind, cyc_wr, mem_addr, e.k, e.w, e.a);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    apply(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R11 reset");
    apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 20'hFFFFF, "R11 reset with strobes");
    idle(1'b0, 1'b0, 1'b1, "R5 idle after reset");

    // R1 + R3: read start despite wr_req high, controller strobe low and adv low
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 20'h12345, "R1 R3 processor start");
    idle(1'b0, 1'b0, 1'b0, "R8 linear beat 1");
    idle(1'b0, 1'b0, 1'b0, "R8 linear beat 2");
    idle(1'b1, 1'b0, 1'b1, "R7 suspend write");
    idle(1'b1, 1'b0, 1'b0, "R7 suspend read");
    idle(1'b0, 1'b0, 1'b0, "R8 linear beat 3");
    idle(1'b0, 1'b0, 1'b1, "R10 wrap to start");

    // R2: controller start with write sampled on its edge
    c_go(20'hABCDE, 1'b1, "R2 controller write start");
    idle(1'b0, 1'b0, 1'b1, "R6 continue write");
    c_go(20'h00F03, 1'b0, "R2 controller read start");

    // R4: sel1_n high blocks the processor strobe mid burst
    apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 20'h77777, "R4 blocked processor strobe");
    apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 20'h77777, "R4 blocked strobe suspend");

    // R5: deselect cases
    apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 20'h55555, "R5 controller sel2 low");
    idle(1'b0, 1'b0, 1'b1, "R5 stay deselected");
    p_go(20'h31337, 1'b0, 1'b0, 1'b1, "R1 restart");
    apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 20'h22222, "R5 processor sel3 high");
    apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 20'h22222, "R5 controller sel1 high");
    idle(1'b1, 1'b0, 1'b0, "R5 stay deselected 2");

    // R2: both strobes low -> processor wins, read
    apply(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 20'h40404, "R1 both strobes low");

    // R8/R9/R10: every start value in both orders, full wrap
    for (int ox = 0; ox < 2; ox++) begin
      for (int st = 0; st < 4; st++) begin
        logic [AW-1:0] a;
        a = 20'hC8F30 | AW'(st);
        p_go(a, ox[0], 1'b0, 1'b1, ox ? "R9 start" : "R8 start");
        for (int b = 0; b < 4; b++) begin
          idle(1'b0, ox[0], b[0], ox ? "R9 R10 xor beat" : "R8 R10 linear beat");
        end
      end
    end

    // R9 example: start 10 interleaved
    c_go(20'h00002, 1'b0, "R9 example start");
    idle(1'b0, 1'b1, 1'b0, "R9 example beat 11");
    idle(1'b0, 1'b1, 1'b0, "R9 example beat 00");
    idle(1'b0, 1'b1, 1'b0, "R9 example beat 01");
    apply(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R11 reset mid burst");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule